// File: doc/BRIEF.md
# Branch Mode and Trap Controller

This block tracks the processor's privilege mode and decides, for each branch instruction, whether the mode changes and whether a trap is raised. The mode is one of three values: normal, monitor or user. The branch kinds are unconditional, index-conditional, mark-and-branch and return.

For each branch the surrounding pipeline supplies the decoded kind and the effective address. It also supplies two flags: whether the address is present in the memory map, and whether it lies in user space. Alongside these it supplies the word it fetched from the access-trap vector at octal location 041. If the target is unmapped, the block requests an access trap. If a monitor-mode branch lands in user space, the block switches to user mode and then fires the monitor-to-user trap when that trap is armed. In both cases the latched trap address is the branch target.

All outputs are registered. Decisions made from the inputs of cycle N appear on the outputs after the clock edge that ends cycle N.

Top module: `brmode_trap_ctl`

## Requirements
- R1: After synchronous reset, the outputs are as follows: `mode` = 0 (normal), `m2u_armed` = 0, `trap_req` = 0, `trap_cause` = 0, `trap_addr` = 0 and `vec_illegal` = 0.
- R2: A branch of any kind whose target is unmapped (`ea_mapped` = 0) and whose vector word is legal does three things on the next cycle. It raises `trap_req`, it sets `trap_cause` = 0 (access trap), and it sets `trap_addr` to the branch's `br_ea`. The mode is unchanged.
- R3: The vector word is legal only when its opcode field, bits [20:15], equals octal 01 (unconditional branch) or octal 43 (mark-and-branch).
- R4: Consider an unconditional (`br_kind` = 0), index (1) or mark-and-branch (2) branch in monitor mode (`mode` = 1), with a mapped target that has `ea_user` = 1. After this branch, `mode` becomes 2 (user) on the next cycle.
- R5: If the monitor-to-user trap is armed when the switch in R4 happens, four things occur on the next cycle. `trap_req` rises, `trap_cause` = 1, `trap_addr` holds the user-mode target `br_ea`, and the trap disarms.
- R6: When an unmapped target meets an illegal vector word, `vec_illegal` pulses for one cycle. No trap is requested, and both `trap_addr` and the mode keep their values.
- R7: `trap_req` is high for only one cycle per trapping branch. `trap_addr` and `trap_cause` hold their values until the next trap.
- R8: A branch with a mapped target and no mode change raises no trap and leaves the mode as it was. This covers return branches (`br_kind` = 3), and branches made in normal or user mode.
- R9: When no branch is presented, `mode_ld` loads `mode_ld_val` (0 normal, 1 monitor, 2 user). A load value of 3 is ignored, and so is a load in a cycle that has `br_valid` = 1.
- R10: `arm_set` arms the monitor-to-user trap and `arm_clr` disarms it; if both are high, `arm_clr` wins. The result is visible on `m2u_armed` on the next cycle. A firing trap disarms regardless of `arm_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | A branch is presented this cycle |
| br_kind | input | 2 | 0 unconditional, 1 index, 2 mark-and-branch, 3 return |
| br_ea | input | ADDR_W | Effective (target) address |
| ea_mapped | input | 1 | Target is present in the memory map |
| ea_user | input | 1 | Target lies in user space |
| vec_word | input | WORD_W | Word fetched from trap vector location 041 |
| arm_set | input | 1 | Arm the monitor-to-user trap |
| arm_clr | input | 1 | Disarm the monitor-to-user trap |
| mode_ld | input | 1 | Load mode from mode_ld_val |
| mode_ld_val | input | 2 | Mode value to load |
| mode | output | 2 | Current mode |
| m2u_armed | output | 1 | Monitor-to-user trap armed |
| trap_req | output | 1 | One-cycle trap request |
| trap_cause | output | 1 | 0 access trap, 1 monitor-to-user trap |
| trap_addr | output | ADDR_W | Latched trap (target) address |
| vec_illegal | output | 1 | Trap vector word was illegal |

## Verification
Directed patterns come first. Unmapped targets are paired with each legal vector opcode and with an illegal one, which separates a trap from a suppressed transfer. Monitor-mode branches into user space are run both unarmed and armed, which shows whether the mode switch happens before the trap check and which address gets latched. Return branches and branches from normal or user mode are included to confirm that nothing changes in those cases. A random phase then mixes mode loads, arm and disarm, mapped and unmapped targets, and collisions between a branch and a load. It compares all outputs with a behavioural model on every clock.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_MONITOR = 2'd1,
    MODE_USER    = 2'd2
  } mode_t;

  typedef enum logic [1:0] {
    BR_UNCOND = 2'd0,
    BR_INDEX  = 2'd1,
    BR_MARK   = 2'd2,
    BR_RETURN = 2'd3
  } br_kind_t;

  localparam int unsigned OPC_W      = 6;
  localparam logic [5:0]  OPC_UNCOND = 6'o01;
  localparam logic [5:0]  OPC_MARK   = 6'o43;
endpackage

// File: rtl/mtc_vec_check.sv
module mtc_vec_check
  import mtc_pkg::*;
#(
  parameter int unsigned WORD_W = 24,
  parameter int unsigned OP_LSB = 15
) (
  input  logic [WORD_W-1:0] vec_word,
  output logic              vec_legal
);
  localparam int unsigned OP_MSB = OP_LSB + OPC_W - 1;
  localparam int unsigned N_OK   = 2;

  logic [OPC_W-1:0] opc;
  logic [N_OK-1:0]  hit;
  logic [OPC_W-1:0] ok_tab [N_OK];

  assign opc       = vec_word[OP_MSB:OP_LSB];
  assign ok_tab[0] = OPC_UNCOND;
  assign ok_tab[1] = OPC_MARK;

  for (genvar g = 0; g < N_OK; g++) begin : g_match
    assign hit[g] = (opc == ok_tab[g]);
  end

  assign vec_legal = |hit;
endmodule

// File: rtl/mtc_branch_eval.sv
module mtc_branch_eval
  import mtc_pkg::*;
(
  input  logic       br_valid,
  input  logic [1:0] br_kind,
  input  logic       ea_mapped,
  input  logic       ea_user,
  input  logic [1:0] cur_mode,
  input  logic       armed,
  input  logic       vec_legal,
  output logic       acc_trap,
  output logic       acc_bad,
  output logic       enter_user,
  output logic       m2u_fire
);
  logic unmapped;
  logic kind_ok;

  assign unmapped   = br_valid & ~ea_mapped;
  assign acc_trap   = unmapped & vec_legal;
  assign acc_bad    = unmapped & ~vec_legal;
  assign kind_ok    = (br_kind != BR_RETURN);
  assign enter_user = br_valid & ea_mapped & ea_user & kind_ok &
                      (cur_mode == MODE_MONITOR);
  assign m2u_fire   = enter_user & armed;
endmodule

// File: rtl/mtc_state.sv
module mtc_state
  import mtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_valid,
  input  logic [ADDR_W-1:0] br_ea,
  input  logic              acc_trap,
  input  logic              acc_bad,
  input  logic              enter_user,
  input  logic              m2u_fire,
  input  logic              arm_set,
  input  logic              arm_clr,
  input  logic              mode_ld,
  input  logic [1:0]        mode_ld_val,
  output logic [1:0]        mode_q,
  output logic              armed_q,
  output logic              trap_q,
  output logic              cause_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              bad_q
);
  logic take_trap;
  logic load_ok;

  assign take_trap = acc_trap | m2u_fire;
  assign load_ok   = mode_ld & ~br_valid & (mode_ld_val != 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_NORMAL;
      armed_q <= 1'b0;
      trap_q  <= 1'b0;
      cause_q <= 1'b0;
      addr_q  <= '0;
      bad_q   <= 1'b0;
    end else begin
      if (enter_user)   mode_q <= MODE_USER;
      else if (load_ok) mode_q <= mode_ld_val;

      if (m2u_fire || arm_clr) armed_q <= 1'b0;
      else if (arm_set)        armed_q <= 1'b1;

      trap_q <= take_trap;
      bad_q  <= acc_bad;
      if (take_trap) begin
        addr_q  <= br_ea;
        cause_q <= m2u_fire;
      end
    end
  end
endmodule

// File: rtl/brmode_trap_ctl.sv
module brmode_trap_ctl
  import mtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned WORD_W = 24,
  parameter int unsigned OP_LSB = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_valid,
  input  logic [1:0]        br_kind,
  input  logic [ADDR_W-1:0] br_ea,
  input  logic              ea_mapped,
  input  logic              ea_user,
  input  logic [WORD_W-1:0] vec_word,
  input  logic              arm_set,
  input  logic              arm_clr,
  input  logic              mode_ld,
  input  logic [1:0]        mode_ld_val,
  output logic [1:0]        mode,
  output logic              m2u_armed,
  output logic              trap_req,
  output logic              trap_cause,
  output logic [ADDR_W-1:0] trap_addr,
  output logic              vec_illegal
);
  logic vec_legal;
  logic acc_trap, acc_bad, enter_user, m2u_fire;

  mtc_vec_check #(.WORD_W(WORD_W), .OP_LSB(OP_LSB)) u_vec (
    .vec_word (vec_word),
    .vec_legal(vec_legal)
  );

  mtc_branch_eval u_eval (
    .br_valid  (br_valid),
    .br_kind   (br_kind),
    .ea_mapped (ea_mapped),
    .ea_user   (ea_user),
    .cur_mode  (mode),
    .armed     (m2u_armed),
    .vec_legal (vec_legal),
    .acc_trap  (acc_trap),
    .acc_bad   (acc_bad),
    .enter_user(enter_user),
    .m2u_fire  (m2u_fire)
  );

  mtc_state #(.ADDR_W(ADDR_W)) u_state (
    .clk        (clk),
    .rst        (rst),
    .br_valid   (br_valid),
    .br_ea      (br_ea),
    .acc_trap   (acc_trap),
    .acc_bad    (acc_bad),
    .enter_user (enter_user),
    .m2u_fire   (m2u_fire),
    .arm_set    (arm_set),
    .arm_clr    (arm_clr),
    .mode_ld    (mode_ld),
    .mode_ld_val(mode_ld_val),
    .mode_q     (mode),
    .armed_q    (m2u_armed),
    .trap_q     (trap_req),
    .cause_q    (trap_cause),
    .addr_q     (trap_addr),
    .bad_q      (vec_illegal)
  );

  AST_ACC_TARGET: assert property (@(posedge clk) disable iff (rst) (br_valid && !ea_mapped && vec_legal) |=> (trap_req && !trap_cause && trap_addr == $past(br_ea))) else $error("access trap address"); // R2
  AST_ENTER_USER: assert property (@(posedge clk) disable iff (rst) (br_valid && ea_mapped && ea_user && br_kind != BR_RETURN && mode == MODE_MONITOR) |=> (mode == MODE_USER)) else $error("no user entry"); // R4
  AST_M2U_TRAP: assert property (@(posedge clk) disable iff (rst) (enter_user && m2u_armed) |=> (trap_req && trap_cause && trap_addr == $past(br_ea) && !m2u_armed)) else $error("m2u trap"); // R5
  AST_ILLEGAL_VEC: assert property (@(posedge clk) disable iff (rst) vec_illegal |-> (!trap_req && $stable(trap_addr) && $stable(mode))) else $error("illegal vector transfer"); // R6
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst) !trap_req |-> ($stable(trap_addr) && $stable(trap_cause))) else $error("trap addr moved"); // R7
  AST_QUIET_BRANCH: assert property (@(posedge clk) disable iff (rst) (br_valid && ea_mapped && !enter_user) |=> ($stable(mode) && !trap_req)) else $error("quiet branch"); // R8
endmodule

// File: tb/brmode_trap_ctl_tb_top.sv
module brmode_trap_ctl_tb_top;
  localparam int ADDR_W = 14;
  localparam int WORD_W = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic br_valid = 1'b0;
  logic [1:0] br_kind = '0;
  logic [ADDR_W-1:0] br_ea = '0;
  logic ea_mapped = 1'b1;
  logic ea_user = 1'b0;
  logic [WORD_W-1:0] vec_word = '0;
  logic arm_set = 1'b0, arm_clr = 1'b0, mode_ld = 1'b0;
  logic [1:0] mode_ld_val = '0;
  logic [1:0] mode;
  logic m2u_armed, trap_req, trap_cause, vec_illegal;
  logic [ADDR_W-1:0] trap_addr;

  always #2.5 clk = ~clk;

  brmode_trap_ctl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) dut_i (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_kind(br_kind), .br_ea(br_ea),
    .ea_mapped(ea_mapped), .ea_user(ea_user), .vec_word(vec_word),
    .arm_set(arm_set), .arm_clr(arm_clr), .mode_ld(mode_ld), .mode_ld_val(mode_ld_val),
    .mode(mode), .m2u_armed(m2u_armed), .trap_req(trap_req), .trap_cause(trap_cause),
    .trap_addr(trap_addr), .vec_illegal(vec_illegal)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit done = 1'b0;

  // behavioural reference
  int m_mode = 0, m_arm = 0, m_trap = 0, m_cause = 0, m_addr = 0, m_bad = 0;

  function automatic logic [WORD_W-1:0] vword(input int opc, input int low);
    return WORD_W'((opc & 63) << 15) | WORD_W'(low & 32'h7fff);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_arm = 0; m_trap = 0; m_cause = 0; m_addr = 0; m_bad = 0;
    end else begin
      int opc;
      bit legal, unm, to_user, fire;
      opc     = int'(vec_word[20:15]);
      legal   = (opc == 8'o01) || (opc == 8'o43);
      unm     = br_valid && !ea_mapped;
      to_user = br_valid && ea_mapped && ea_user && br_kind != 2'd3 && m_mode == 1;
      fire    = to_user && (m_arm == 1);
      m_trap  = (unm && legal) || fire;
      m_bad   = unm && !legal;
      if (m_trap) begin
        m_addr  = int'(br_ea);
        m_cause = fire ? 1 : 0;
      end
      if (to_user) m_mode = 2;
      else if (mode_ld && !br_valid && mode_ld_val != 2'd3) m_mode = int'(mode_ld_val);
      if (fire || arm_clr) m_arm = 0;
      else if (arm_set) m_arm = 1;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("mode", int'(mode), m_mode);
      chk("armed", int'(m2u_armed), m_arm);
      chk("trap_req", int'(trap_req), m_trap);
      chk("trap_cause", int'(trap_cause), m_cause);
      chk("trap_addr", int'(trap_addr), m_addr);
      chk("vec_illegal", int'(vec_illegal), m_bad);
    end
  end

  task automatic idle();
    br_valid = 0; arm_set = 0; arm_clr = 0; mode_ld = 0;
    @(negedge clk);
  endtask

  task automatic branch(input int kind, input int ea, input bit mapped, input bit usr, input int opc);
    br_valid = 1; br_kind = 2'(kind); br_ea = ADDR_W'(ea);
    ea_mapped = mapped; ea_user = usr; vec_word = vword(opc, ea * 7);
    arm_set = 0; arm_clr = 0; mode_ld = 0;
    @(negedge clk);
    br_valid = 0;
  endtask

  task automatic load_mode(input int m);
    br_valid = 0; mode_ld = 1; mode_ld_val = 2'(m);
    @(negedge clk);
    mode_ld = 0;
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000 && !done) begin
        done = 1'b1;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    tag = "R1";
    checks++;
    if (mode !== 2'd0 || m2u_armed !== 1'b0 || trap_req !== 1'b0 || trap_cause !== 1'b0 ||
        trap_addr !== '0 || vec_illegal !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset state actual %0d/%0d/%0d/%0d/%0d/%0d expected 0/0/0/0/0/0",
               mode, m2u_armed, trap_req, trap_cause, trap_addr, vec_illegal);
    end

    tag = "R2";
    for (int k = 0; k < 4; k++) begin
      branch(k, 14'h0100 + k, 0, 0, 8'o01);
      idle();
    end
    tag = "R3";
    branch(2, 14'h0222, 0, 1, 8'o43);
    branch(0, 14'h0333, 0, 0, 8'o43);
    tag = "R6";
    branch(1, 14'h0444, 0, 0, 8'o02);
    branch(0, 14'h0555, 0, 0, 8'o00);
    idle();
    tag = "R7";
    idle(); idle();
    tag = "R9";
    load_mode(1);
    load_mode(3);
    br_valid = 1; br_kind = 2'd3; ea_mapped = 1; ea_user = 0; mode_ld = 1; mode_ld_val = 2'd2;
    @(negedge clk);
    idle();
    tag = "R4";
    branch(2, 14'h2000, 1, 1, 8'o01);
    idle();
    tag = "R8";
    branch(0, 14'h2100, 1, 1, 8'o01);
    load_mode(1);
    branch(3, 14'h2200, 1, 1, 8'o01);
    load_mode(0);
    branch(0, 14'h2300, 1, 1, 8'o01);
    tag = "R10";
    arm_set = 1; arm_clr = 1; @(negedge clk);
    arm_clr = 0; @(negedge clk);
    arm_set = 0; idle();
    tag = "R5";
    load_mode(1);
    branch(1, 14'h3abc, 1, 1, 8'o77);
    idle(); idle();
    load_mode(1);
    arm_set = 1; @(negedge clk);
    br_valid = 1; br_kind = 2'd0; br_ea = 14'h1234; ea_mapped = 1; ea_user = 1;
    arm_set = 1; @(negedge clk);
    idle(); idle();

    tag = "R2/R4/R5/R6/R8/R9/R10";
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = int'($urandom);
      br_valid    = r[0];
      br_kind     = 2'(r[2:1]);
      br_ea       = ADDR_W'($urandom);
      ea_mapped   = (r[4:3] != 2'b00);
      ea_user     = r[5];
      case (r[7:6])
        2'd0: vec_word = vword(8'o01, r >> 8);
        2'd1: vec_word = vword(8'o43, r >> 8);
        default: vec_word = WORD_W'($urandom);
      endcase
      arm_set     = (r[10:8] == 3'd0);
      arm_clr     = (r[14:11] == 4'd0);
      mode_ld     = (r[17:15] == 3'd0);
      mode_ld_val = 2'(r[19:18]);
      @(negedge clk);
    end
    idle();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule